// File: doc/BRIEF.md
# Synthesizer Divider, Phase Detector and Lock Monitor

This block is the digital heart of a tuner frequency synthesizer. Two tick strobes, one per crystal period and one per prescaled VCO period, each synchronous to the system clock, drive two dividers. The reference divider has a fixed modulus of 512. The programmable divider has a 15-bit modulus called the scale factor. With a divide-by-16 prescaler ahead of it, the loop settles at a VCO frequency of 16 times the scale factor times the crystal frequency divided by 512. So a 4 MHz crystal gives a 7.8125 kHz comparison rate and 125 kHz tuning steps.

The wrap events of the two dividers feed a dual-flag phase/frequency detector. Its up and down requests, a pump-enable line, a driver-enable line and a current-level bit stand in for the analog charge pump and loop amplifier. A lock monitor measures how long each detector pulse lasts and raises a lock flag once the loop has been quiet for several comparison periods.

Control inputs can float the pump, switch the driver off, select the pump current, route the divider outputs to test pins, or shut the whole loop down. A scale factor of zero also shuts the loop down.

Top module: `synth_pll_core`

## Requirements
- R1: The reference divider emits one wrap event for every 512 accepted `refTick` strobes, and while `divTest` is 1 each event appears as a one-cycle pulse on `refDivOut`.
- R2: For a scale factor from 256 to 32767, the programmable divider emits one wrap event for every `scaleFactor` accepted `vcoTick` strobes, shown on `vcoDivOut` while `divTest` is 1.
- R3: When the reference event leads, `pumpUp` is asserted until the VCO event arrives. When the VCO event leads, `pumpDown` is asserted until the reference event arrives.
- R4: While `cpTristate` is 1, `pumpEnable` is 0 and neither `pumpUp` nor `pumpDown` is asserted.
- R5: While `drvOff` is 1, `driveEnable` is 0. The pump lines are unaffected.
- R6: `lockFlag` rises on the fourth consecutive reference event during which no detector pulse has lasted more than 4 clock cycles.
- R7: `lockFlag` falls in the cycle after a detector pulse passes 4 clock cycles.
- R8: While `pllDisable` is 1, or `scaleFactor` is 0, both dividers are held, so no events occur. In that state `pumpEnable`, `driveEnable` and `lockFlag` are all 0.
- R9: `pumpHigh` is 1 when `hiCurrent` is 1 and 0 when it is 0.
- R10: While `divTest` is 0, `refDivOut` and `vcoDivOut` stay 0.
- R11: A nonzero scale factor below 256 holds the programmable divider, so no VCO events occur.
- R12: `pumpUp` and `pumpDown` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| refTick | input | 1 | One strobe per crystal period |
| vcoTick | input | 1 | One strobe per prescaled VCO period |
| scaleFactor | input | 15 | Programmable divider modulus |
| cpTristate | input | 1 | Float the charge pump |
| drvOff | input | 1 | Switch off the tuning driver |
| divTest | input | 1 | Route the divider events to the test pins |
| hiCurrent | input | 1 | Select the high pump current |
| pllDisable | input | 1 | Shut the whole loop down |
| pumpUp | output | 1 | Raise tuning voltage request |
| pumpDown | output | 1 | Lower tuning voltage request |
| pumpEnable | output | 1 | Pump driven (not floating) |
| driveEnable | output | 1 | Tuning driver active |
| pumpHigh | output | 1 | Pump current level, 1 is high |
| lockFlag | output | 1 | Loop in lock |
| refDivOut | output | 1 | Reference divider test pulse |
| vcoDivOut | output | 1 | Programmable divider test pulse |

## Verification
Two events can land in the same cycle: a reference wrap and a VCO wrap. When the two dividers start together with equal moduli, their events always coincide. The detector then sets both flags at once and clears them in the next cycle, so neither pump line may assert and the lock count must still advance. The bench provokes this by releasing reset with both tick streams running every cycle. It judges the result by the lock flag timing, and it checks that no up or down pulse is seen in any observation window.

// File: rtl/pll_pkg.sv
package pll_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic holdRef;   // keep reference divider at zero
    logic holdVco;   // keep programmable divider at zero
    logic clearPfd;  // clear detector flags and width count
  } ctl_strobe_t;

endpackage

// File: rtl/pll_datapath.sv
module pll_datapath
  import pll_pkg::*;
#(
  parameter int REF_DIV  = 512,
  parameter int SF_W     = 15,
  parameter int LOCK_WIN = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            refTick,
  input  logic            vcoTick,
  input  logic [SF_W-1:0] sf,
  input  ctl_strobe_t     strb,
  output logic            refPulse,
  output logic            vcoPulse,
  output logic            upFlag,
  output logic            dnFlag,
  output logic            pulseWide
);

  localparam int REF_W = $clog2(REF_DIV);
  localparam int WID_W = $clog2(LOCK_WIN + 2);
  localparam logic [REF_W-1:0] REF_LAST = REF_W'(REF_DIV - 1);
  localparam logic [WID_W-1:0] WID_MAX  = WID_W'(LOCK_WIN + 1);
  localparam logic [WID_W-1:0] WID_LIM  = WID_W'(LOCK_WIN);

  logic [REF_W-1:0] refCnt;
  logic [SF_W-1:0]  vcoCnt;
  logic [SF_W:0]    vcoNext;
  logic [WID_W-1:0] widthCnt;

  // Reference divider, fixed modulus
  always_ff @(posedge clk) begin
    if (!rstN || strb.holdRef) begin
      refCnt   <= '0;
      refPulse <= 1'b0;
    end else if (refTick) begin
      if (refCnt == REF_LAST) begin
        refCnt   <= '0;
        refPulse <= 1'b1;
      end else begin
        refCnt   <= refCnt + 1'b1;
        refPulse <= 1'b0;
      end
    end else begin
      refPulse <= 1'b0;
    end
  end

  // Programmable divider, modulus = sf
  assign vcoNext = {1'b0, vcoCnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN || strb.holdVco) begin
      vcoCnt   <= '0;
      vcoPulse <= 1'b0;
    end else if (vcoTick) begin
      if (vcoNext >= {1'b0, sf}) begin
        vcoCnt   <= '0;
        vcoPulse <= 1'b1;
      end else begin
        vcoCnt   <= vcoNext[SF_W-1:0];
        vcoPulse <= 1'b0;
      end
    end else begin
      vcoPulse <= 1'b0;
    end
  end

  // Dual-flag phase/frequency detector
  always_ff @(posedge clk) begin
    if (!rstN || strb.clearPfd) begin
      upFlag <= 1'b0;
      dnFlag <= 1'b0;
    end else if (upFlag && dnFlag) begin
      upFlag <= 1'b0;
      dnFlag <= 1'b0;
    end else begin
      upFlag <= upFlag | refPulse;
      dnFlag <= dnFlag | vcoPulse;
    end
  end

  // Detector pulse width, saturating
  always_ff @(posedge clk) begin
    if (!rstN || strb.clearPfd || !(upFlag || dnFlag)) begin
      widthCnt <= '0;
    end else if (widthCnt != WID_MAX) begin
      widthCnt <= widthCnt + 1'b1;
    end
  end

  assign pulseWide = (widthCnt > WID_LIM);

endmodule

// File: rtl/pll_control.sv
module pll_control
  import pll_pkg::*;
#(
  parameter int SF_W       = 15,
  parameter int MIN_SF     = 256,
  parameter int LOCK_COUNT = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [SF_W-1:0] sf,
  input  logic            pllDisable,
  input  logic            cpTristate,
  input  logic            drvOff,
  input  logic            divTest,
  input  logic            hiCurrent,
  input  logic            refPulse,
  input  logic            vcoPulse,
  input  logic            upFlag,
  input  logic            dnFlag,
  input  logic            pulseWide,
  output ctl_strobe_t     strb,
  output logic            pumpUp,
  output logic            pumpDown,
  output logic            pumpEnable,
  output logic            driveEnable,
  output logic            pumpHigh,
  output logic            lockFlag,
  output logic            refDivOut,
  output logic            vcoDivOut
);

  localparam int GC_W = $clog2(LOCK_COUNT + 1);
  localparam logic [GC_W-1:0] GC_LAST = GC_W'(LOCK_COUNT - 1);
  localparam logic [SF_W-1:0] SF_MIN  = SF_W'(MIN_SF);

  logic            loopOff;
  logic            sfValid;
  logic [GC_W-1:0] goodCnt;

  assign loopOff = pllDisable || (sf == '0);
  assign sfValid = (sf >= SF_MIN);

  always_comb begin
    strb.holdRef  = loopOff;
    strb.holdVco  = loopOff || !sfValid;
    strb.clearPfd = loopOff;
  end

  assign pumpEnable  = !loopOff && !cpTristate;
  assign driveEnable = !loopOff && !drvOff;
  assign pumpUp      = pumpEnable && upFlag && !dnFlag;
  assign pumpDown    = pumpEnable && dnFlag && !upFlag;
  assign pumpHigh    = hiCurrent;
  assign refDivOut   = divTest && refPulse;
  assign vcoDivOut   = divTest && vcoPulse;

  // Lock monitor: count quiet comparison periods
  always_ff @(posedge clk) begin
    if (!rstN || loopOff || pulseWide) begin
      goodCnt  <= '0;
      lockFlag <= 1'b0;
    end else if (refPulse && !lockFlag) begin
      if (goodCnt == GC_LAST) begin
        lockFlag <= 1'b1;
      end else begin
        goodCnt <= goodCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/synth_pll_core.sv
module synth_pll_core
  import pll_pkg::*;
#(
  parameter int REF_DIV    = 512,
  parameter int SF_W       = 15,
  parameter int MIN_SF     = 256,
  parameter int LOCK_WIN   = 4,
  parameter int LOCK_COUNT = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            refTick,
  input  logic            vcoTick,
  input  logic [SF_W-1:0] scaleFactor,
  input  logic            cpTristate,
  input  logic            drvOff,
  input  logic            divTest,
  input  logic            hiCurrent,
  input  logic            pllDisable,
  output logic            pumpUp,
  output logic            pumpDown,
  output logic            pumpEnable,
  output logic            driveEnable,
  output logic            pumpHigh,
  output logic            lockFlag,
  output logic            refDivOut,
  output logic            vcoDivOut
);

  ctl_strobe_t strb;
  logic refPulse, vcoPulse, upFlag, dnFlag, pulseWide;

  pll_datapath #(
    .REF_DIV (REF_DIV),
    .SF_W    (SF_W),
    .LOCK_WIN(LOCK_WIN)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .refTick  (refTick),
    .vcoTick  (vcoTick),
    .sf       (scaleFactor),
    .strb     (strb),
    .refPulse (refPulse),
    .vcoPulse (vcoPulse),
    .upFlag   (upFlag),
    .dnFlag   (dnFlag),
    .pulseWide(pulseWide)
  );

  pll_control #(
    .SF_W      (SF_W),
    .MIN_SF    (MIN_SF),
    .LOCK_COUNT(LOCK_COUNT)
  ) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .sf         (scaleFactor),
    .pllDisable (pllDisable),
    .cpTristate (cpTristate),
    .drvOff     (drvOff),
    .divTest    (divTest),
    .hiCurrent  (hiCurrent),
    .refPulse   (refPulse),
    .vcoPulse   (vcoPulse),
    .upFlag     (upFlag),
    .dnFlag     (dnFlag),
    .pulseWide  (pulseWide),
    .strb       (strb),
    .pumpUp     (pumpUp),
    .pumpDown   (pumpDown),
    .pumpEnable (pumpEnable),
    .driveEnable(driveEnable),
    .pumpHigh   (pumpHigh),
    .lockFlag   (lockFlag),
    .refDivOut  (refDivOut),
    .vcoDivOut  (vcoDivOut)
  );

endmodule

// File: rtl/synth_pll_checker.sv
module synth_pll_checker #(
  parameter int SF_W = 15
) (
  input logic            clk,
  input logic            rstN,
  input logic [SF_W-1:0] scaleFactor,
  input logic            cpTristate,
  input logic            drvOff,
  input logic            divTest,
  input logic            hiCurrent,
  input logic            pllDisable,
  input logic            pumpUp,
  input logic            pumpDown,
  input logic            pumpEnable,
  input logic            driveEnable,
  input logic            pumpHigh,
  input logic            lockFlag,
  input logic            refDivOut,
  input logic            vcoDivOut
);

  a_r4_tristate_quiet: assert property (@(posedge clk) disable iff (!rstN)
    cpTristate |-> (!pumpUp && !pumpDown && !pumpEnable));

  a_r5_driver_off: assert property (@(posedge clk) disable iff (!rstN)
    drvOff |-> !driveEnable);

  a_r8_disable_unlocks: assert property (@(posedge clk) disable iff (!rstN)
    (pllDisable || scaleFactor == '0) |=> !lockFlag);

  a_r8_disable_outputs: assert property (@(posedge clk) disable iff (!rstN)
    pllDisable |-> (!pumpEnable && !driveEnable));

  a_r9_current_level: assert property (@(posedge clk) disable iff (!rstN)
    pumpHigh == hiCurrent);

  a_r10_test_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !divTest |-> (!refDivOut && !vcoDivOut));

  a_r12_pump_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(pumpUp && pumpDown));

endmodule

bind synth_pll_core synth_pll_checker #(.SF_W(SF_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .scaleFactor(scaleFactor),
  .cpTristate (cpTristate),
  .drvOff     (drvOff),
  .divTest    (divTest),
  .hiCurrent  (hiCurrent),
  .pllDisable (pllDisable),
  .pumpUp     (pumpUp),
  .pumpDown   (pumpDown),
  .pumpEnable (pumpEnable),
  .driveEnable(driveEnable),
  .pumpHigh   (pumpHigh),
  .lockFlag   (lockFlag),
  .refDivOut  (refDivOut),
  .vcoDivOut  (vcoDivOut)
);

// File: tb/tb_synth_pll_core.sv
module tb_synth_pll_core;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        refTick = 1'b0, vcoTick = 1'b0;
  logic [14:0] scaleFactor = 15'd512;
  logic        cpTristate = 0, drvOff = 0, divTest = 0, hiCurrent = 0, pllDisable = 0;
  logic        pumpUp, pumpDown, pumpEnable, driveEnable, pumpHigh, lockFlag;
  logic        refDivOut, vcoDivOut;

  int checkCnt = 0, failCnt = 0, cycles = 0;
  bit done = 0;
  int refStep = 1, refPh = 0;
  int upSeen, dnSeen, bothSeen, refCnt, vcoCnt, refInt, vcoInt;

  always #4 clk = ~clk;

  synth_pll_core dut (
    .clk(clk), .rstN(rstN), .refTick(refTick), .vcoTick(vcoTick),
    .scaleFactor(scaleFactor), .cpTristate(cpTristate), .drvOff(drvOff),
    .divTest(divTest), .hiCurrent(hiCurrent), .pllDisable(pllDisable),
    .pumpUp(pumpUp), .pumpDown(pumpDown), .pumpEnable(pumpEnable),
    .driveEnable(driveEnable), .pumpHigh(pumpHigh), .lockFlag(lockFlag),
    .refDivOut(refDivOut), .vcoDivOut(vcoDivOut)
  );

  // tick generators, driven away from the active edge
  always @(negedge clk) begin
    refTick = (refPh == 0);
    refPh   = (refPh + 1) % refStep;
    vcoTick = 1'b1;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      failCnt++;
      checkCnt++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [14:0] sf, input int rstep);
    @(negedge clk);
    rstN = 0; scaleFactor = sf; refStep = rstep; refPh = 0;
    cpTristate = 0; drvOff = 0; divTest = 0; hiCurrent = 0; pllDisable = 0;
    repeat (4) @(negedge clk);
    rstN = 1;
  endtask

  task automatic watch(input int n);
    int lastR = -1, lastV = -1;
    upSeen = 0; dnSeen = 0; bothSeen = 0; refCnt = 0; vcoCnt = 0; refInt = 0; vcoInt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pumpUp) upSeen++;
      if (pumpDown) dnSeen++;
      if (pumpUp && pumpDown) bothSeen++;
      if (refDivOut) begin if (lastR >= 0) refInt = i - lastR; lastR = i; refCnt++; end
      if (vcoDivOut) begin if (lastV >= 0) vcoInt = i - lastV; lastV = i; vcoCnt++; end
    end
  endtask

  task automatic t_reset();
    do_reset(15'd512, 1);
    #1;
    check(!lockFlag && !pumpUp && !pumpDown, "R6 reset state", lockFlag, 0);
  endtask

  // R6 aligned dividers: coincident events, lock after 4th comparison
  task automatic t_lock();
    do_reset(15'd512, 1);
    watch(1792);
    check(lockFlag == 0, "R6 not yet locked at 3.5 periods", lockFlag, 0);
    check(upSeen == 0 && dnSeen == 0, "R3 coincident events give no pump", upSeen + dnSeen, 0);
    watch(512);
    check(lockFlag == 1, "R6 locked at 4.5 periods", lockFlag, 1);
    check(bothSeen == 0, "R12 pumps exclusive", bothSeen, 0);
  endtask

  // R3/R7 slower VCO: reference leads, lock lost
  task automatic t_up();
    t_lock();
    scaleFactor = 15'd520;
    watch(512);
    check(upSeen > 0, "R3 up when reference leads", upSeen, 1);
    check(dnSeen == 0, "R3 no down when reference leads", dnSeen, 0);
    check(lockFlag == 0, "R7 lock cleared on wide pulse", lockFlag, 0);
    check(bothSeen == 0, "R12 pumps exclusive", bothSeen, 0);
  endtask

  task automatic t_down();
    t_lock();
    scaleFactor = 15'd504;
    watch(512);
    check(dnSeen > 0, "R3 down when VCO leads", dnSeen, 1);
    check(upSeen == 0, "R3 no up when VCO leads", upSeen, 0);
    check(lockFlag == 0, "R7 lock cleared on wide pulse", lockFlag, 0);
  endtask

  task automatic t_tristate();
    do_reset(15'd520, 1);
    cpTristate = 1;
    watch(2048);
    check(upSeen == 0 && dnSeen == 0, "R4 pump floats", upSeen + dnSeen, 0);
    check(pumpEnable == 0, "R4 pumpEnable low", pumpEnable, 0);
    cpTristate = 0;
    watch(1024);
    check(upSeen > 0, "R4 pump resumes", upSeen, 1);
    check(pumpEnable == 1, "R4 pumpEnable high", pumpEnable, 1);
  endtask

  task automatic t_drive();
    do_reset(15'd512, 1);
    drvOff = 1;
    watch(4);
    check(driveEnable == 0, "R5 driver off", driveEnable, 0);
    check(pumpEnable == 1, "R5 pump unaffected", pumpEnable, 1);
    drvOff = 0;
    watch(4);
    check(driveEnable == 1, "R5 driver on", driveEnable, 1);
  endtask

  task automatic t_current();
    hiCurrent = 1; #1;
    check(pumpHigh == 1, "R9 high current", pumpHigh, 1);
    hiCurrent = 0; #1;
    check(pumpHigh == 0, "R9 low current", pumpHigh, 0);
  endtask

  task automatic t_ratio();
    do_reset(15'd300, 2);
    divTest = 1;
    watch(2200);
    check(refInt == 1024, "R1 reference ratio 512 ticks", refInt, 1024);
    check(vcoInt == 300, "R2 programmable ratio", vcoInt, 300);
    scaleFactor = 15'd256;
    watch(700);
    check(vcoInt == 256, "R2 minimum ratio", vcoInt, 256);
    divTest = 0;
    watch(1100);
    check(refCnt == 0 && vcoCnt == 0, "R10 test pins quiet", refCnt + vcoCnt, 0);
  endtask

  task automatic t_invalid();
    do_reset(15'd100, 1);
    divTest = 1;
    watch(1100);
    check(vcoCnt == 0, "R11 low modulus holds divider", vcoCnt, 0);
    check(refCnt == 2, "R11 reference still runs", refCnt, 2);
    check(lockFlag == 0, "R11 no lock", lockFlag, 0);
  endtask

  task automatic t_disable();
    t_lock();
    divTest = 1;
    pllDisable = 1;
    watch(1100);
    check(lockFlag == 0, "R8 disable unlocks", lockFlag, 0);
    check(pumpEnable == 0 && driveEnable == 0, "R8 disable outputs", pumpEnable + driveEnable, 0);
    check(refCnt == 0 && vcoCnt == 0, "R8 dividers held", refCnt + vcoCnt, 0);
    pllDisable = 0;
    scaleFactor = 15'd0;
    watch(1100);
    check(refCnt == 0 && vcoCnt == 0 && lockFlag == 0, "R8 zero modulus disables", refCnt + vcoCnt, 0);
    check(driveEnable == 0, "R8 zero modulus driver off", driveEnable, 0);
  endtask

  initial begin
    t_reset();
    t_lock();
    t_up();
    t_down();
    t_tristate();
    t_drive();
    t_current();
    t_ratio();
    t_invalid();
    t_disable();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

endmodule